// File: doc/BRIEF.md
# Accumulator CPU Fetch-Decode Controller

This block sequences instruction fetch and decode for a small 8-bit accumulator machine. It owns the program counter, the memory address register, the memory data register and the instruction register. It moves an instruction word through them in a fixed four-step order. It then splits the held word into a 3-bit opcode and a 5-bit operand and turns the opcode into one of eight one-hot instruction lines. Sums of products of those lines, gated by the execute and write-back states, produce the control strobes. The accumulator, the ALU and the memory array sit outside the block. The controller gives them an address, a write strobe, an accumulator write strobe with an ALU function select, and a halted flag. It takes back the read data and a zero flag that reports whether the accumulator is zero.

The state machine has seven named states. ST_MAR copies PC into MAR. ST_WAIT covers the one-cycle synchronous read of memory. ST_MDR captures the read data into MDR and advances PC. ST_IR copies MDR into IR under an enable that no other register shares. ST_EXEC performs the decoded action. ST_WB is the accumulator write for instructions that read a memory operand. ST_HALT is a terminal state.

The transitions are as follows:
- ST_MAR goes to ST_WAIT, ST_WAIT to ST_MDR, ST_MDR to ST_IR, and ST_IR to ST_EXEC.
- ST_EXEC goes to ST_WB for load, add and subtract. It goes to ST_HALT for halt, and back to ST_MAR for the other opcodes.
- ST_WB goes to ST_MAR.
- ST_HALT stays in ST_HALT until reset.

Top module: `fetch_decode_ctrl`

## Requirements
- R1: A synchronous reset places the NOP word 0x00 in IR, clears PC, MAR and MDR, and enters ST_MAR. No strobe (acc_we, mem_we, pc_load, halted) is asserted in reset or before the first fetch completes, and the first fetch reads address 0.
- R2: Every instruction begins with four fetch cycles in the order ST_MAR, ST_WAIT, ST_MDR, ST_IR. mem_addr equals the fetch PC in the second and third of these cycles, and no strobe is asserted in any of them.
- R3: IR is written only in ST_IR, from MDR. In that cycle no other register write enable is active, and IR holds its value in every other cycle.
- R4: The opcode is instruction bits [7:5] and the operand is bits [4:0]. The opcode map is 000 NOP, 001 LDA, 010 STA, 011 ADD, 100 SUB, 101 JMP, 110 BNZ, 111 HLT.
- R5: The opcode decoder asserts exactly one of its eight instruction lines in every cycle.
- R6: LDA, ADD and SUB drive mem_addr with the operand in ST_EXEC. In the following cycle they assert acc_we for exactly one cycle, with alu_op 0 (pass read data) for LDA, 1 (add) for ADD and 2 (subtract) for SUB.
- R7: STA asserts mem_we for exactly one cycle, in ST_EXEC, with mem_addr equal to the operand.
- R8: JMP asserts pc_load in ST_EXEC, and the next fetch reads from the operand address.
- R9: BNZ asserts pc_load and branches to the operand only when zero_flag is low. When zero_flag is high, fetch continues at the next sequential address.
- R10: HLT raises halted from the cycle after its execute cycle and holds it until reset. While halted, mem_addr stays constant and acc_we, mem_we and pc_load stay low.
- R11: NOP asserts no strobe and takes five cycles in total.
- R12: PC advances by one after each fetch, modulo 32, so the fetch after address 31 reads address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 5 | Memory address (MAR during fetch, operand during execute) |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| mem_we | output | 1 | Memory write strobe (STA) |
| zero_flag | input | 1 | High when the accumulator is zero |
| acc_we | output | 1 | Accumulator write strobe |
| alu_op | output | 2 | ALU function: 0 pass, 1 add, 2 subtract |
| pc_load | output | 1 | PC is loaded from the operand this cycle |
| halted | output | 1 | Controller has executed HLT |

## Verification
On every cycle the assertions check these behaviours: the one-hot decode, the exclusive IR enable, IR holding its value outside ST_IR, the fetch step order, single-cycle write strobes, the write address tracking the operand, and halt being sticky and quiet. The cycle-exact placement of each strobe relative to the fetch depends on instruction history. The same is true of branch targets, whether BNZ is taken for a given accumulator value, PC wrap-around, and a clean restart after reset. Only the bench's scenarios show these. It runs a reference interpreter over every one of the 256 instruction encodings and over directed loop and wrap programs.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    localparam int OPC_W = 3;
    localparam int N_OPS = 1 << OPC_W;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP = 3'd0,
        OP_LDA = 3'd1,
        OP_STA = 3'd2,
        OP_ADD = 3'd3,
        OP_SUB = 3'd4,
        OP_JMP = 3'd5,
        OP_BNZ = 3'd6,
        OP_HLT = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        ST_MAR  = 3'd0,
        ST_WAIT = 3'd1,
        ST_MDR  = 3'd2,
        ST_IR   = 3'd3,
        ST_EXEC = 3'd4,
        ST_WB   = 3'd5,
        ST_HALT = 3'd6
    } fsm_e;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_SUB  = 2'd2
    } alu_e;

endpackage

// File: rtl/fdc_opdecode.sv
module fdc_opdecode
    import fdc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic [N_OPS-1:0] lines
);

    // 3-to-8 decoder: one comparator per instruction line.
    for (genvar k = 0; k < N_OPS; k++) begin : g_line
        assign lines[k] = (opcode == OPC_W'(k));
    end

endmodule

// File: rtl/fdc_strobes.sv
module fdc_strobes
    import fdc_pkg::*;
(
    input  logic [N_OPS-1:0] lines,
    input  logic             exec_en,
    input  logic             wb_en,
    input  logic             zero_flag,
    output logic             acc_we,
    output logic [1:0]       alu_op,
    output logic             mem_we,
    output logic             pc_load,
    output logic             need_wb,
    output logic             halt_req
);

    logic rd_operand;
    logic take_branch;

    // Sum-of-products control derived from instruction lines.
    always_comb begin
        rd_operand  = lines[OP_LDA] | lines[OP_ADD] | lines[OP_SUB];
        take_branch = lines[OP_JMP] | (lines[OP_BNZ] & ~zero_flag);

        need_wb  = rd_operand;
        halt_req = lines[OP_HLT];
        acc_we   = wb_en & rd_operand;
        mem_we   = exec_en & lines[OP_STA];
        pc_load  = exec_en & take_branch;

        if (!wb_en)
            alu_op = ALU_PASS;
        else if (lines[OP_SUB])
            alu_op = ALU_SUB;
        else if (lines[OP_ADD])
            alu_op = ALU_ADD;
        else
            alu_op = ALU_PASS;
    end

endmodule

// File: rtl/fdc_sequencer.sv
module fdc_sequencer
    import fdc_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [WORD_W-1:0]         mem_rdata,
    input  logic                      pc_load,
    input  logic                      need_wb,
    input  logic                      halt_req,
    output logic [OPC_W-1:0]          opcode,
    output logic [WORD_W-OPC_W-1:0]   operand,
    output logic [WORD_W-OPC_W-1:0]   mem_addr,
    output logic                      exec_en,
    output logic                      wb_en,
    output logic                      halted
);

    localparam int OPND_W = WORD_W - OPC_W;
    localparam logic [WORD_W-1:0] NOP_WORD = {OP_NOP, {OPND_W{1'b0}}};

    fsm_e state, nxt;

    logic [OPND_W-1:0] pc, mar;
    logic [WORD_W-1:0] mdr, ir;

    logic mar_en, mdr_en, ir_en, pc_inc, opnd_addr;

    // State register.
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_MAR;
        else
            state <= nxt;
    end

    // Transitions.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_MAR:  nxt = ST_WAIT;
            ST_WAIT: nxt = ST_MDR;
            ST_MDR:  nxt = ST_IR;
            ST_IR:   nxt = ST_EXEC;
            ST_EXEC: begin
                if (need_wb)
                    nxt = ST_WB;
                else if (halt_req)
                    nxt = ST_HALT;
                else
                    nxt = ST_MAR;
            end
            ST_WB:   nxt = ST_MAR;
            ST_HALT: nxt = ST_HALT;
            default: nxt = ST_MAR;
        endcase
    end

    // Per-state enables.
    always_comb begin
        mar_en    = 1'b0;
        mdr_en    = 1'b0;
        ir_en     = 1'b0;
        pc_inc    = 1'b0;
        exec_en   = 1'b0;
        wb_en     = 1'b0;
        halted    = 1'b0;
        opnd_addr = 1'b0;
        unique case (state)
            ST_MAR:  mar_en = 1'b1;
            ST_WAIT: ;
            ST_MDR:  begin
                mdr_en = 1'b1;
                pc_inc = 1'b1;
            end
            ST_IR:   ir_en = 1'b1;
            ST_EXEC: begin
                exec_en   = 1'b1;
                opnd_addr = 1'b1;
            end
            ST_WB:   begin
                wb_en     = 1'b1;
                opnd_addr = 1'b1;
            end
            ST_HALT: halted = 1'b1;
            default: ;
        endcase
    end

    // Datapath registers of the fetch chain.
    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            mar <= '0;
            mdr <= NOP_WORD;
            ir  <= NOP_WORD;
        end else begin
            if (mar_en)
                mar <= pc;
            if (mdr_en)
                mdr <= mem_rdata;
            if (ir_en)
                ir <= mdr;
            if (pc_load)
                pc <= operand;
            else if (pc_inc)
                pc <= pc + 1'b1;
        end
    end

    assign opcode   = ir[WORD_W-1:OPND_W];
    assign operand  = ir[OPND_W-1:0];
    assign mem_addr = opnd_addr ? operand : mar;

    // Checks on the fetch chain.
    logic armed;
    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else
            armed <= 1'b1;
    end

    a_r3_ir_exclusive: assert property (@(posedge clk) disable iff (rst)
        ir_en |-> !(mar_en || mdr_en || pc_inc || pc_load || exec_en || wb_en));

    a_r3_ir_hold: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(ir_en)) |-> $stable(ir));

    a_r2_mdr_after_wait: assert property (@(posedge clk) disable iff (rst)
        (armed && state == ST_MDR) |-> $past(state) == ST_WAIT);

    a_r2_ir_after_mdr: assert property (@(posedge clk) disable iff (rst)
        (armed && state == ST_IR) |-> $past(state) == ST_MDR);

    a_r8_pc_moves_only_when_enabled: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(pc_inc) && !$past(pc_load)) |-> $stable(pc));

endmodule

// File: rtl/fetch_decode_ctrl.sv
module fetch_decode_ctrl
    import fdc_pkg::*;
#(
    parameter  int WORD_W = 8,
    localparam int OPND_W = WORD_W - fdc_pkg::OPC_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [OPND_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_we,
    input  logic              zero_flag,
    output logic              acc_we,
    output logic [1:0]        alu_op,
    output logic              pc_load,
    output logic              halted
);

    logic [OPC_W-1:0]  opcode;
    logic [OPND_W-1:0] operand;
    logic [N_OPS-1:0]  lines;
    logic              exec_en, wb_en, need_wb, halt_req;

    fdc_sequencer #(.WORD_W(WORD_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .pc_load   (pc_load),
        .need_wb   (need_wb),
        .halt_req  (halt_req),
        .opcode    (opcode),
        .operand   (operand),
        .mem_addr  (mem_addr),
        .exec_en   (exec_en),
        .wb_en     (wb_en),
        .halted    (halted)
    );

    fdc_opdecode u_dec (
        .opcode (opcode),
        .lines  (lines)
    );

    fdc_strobes u_ctl (
        .lines     (lines),
        .exec_en   (exec_en),
        .wb_en     (wb_en),
        .zero_flag (zero_flag),
        .acc_we    (acc_we),
        .alu_op    (alu_op),
        .mem_we    (mem_we),
        .pc_load   (pc_load),
        .need_wb   (need_wb),
        .halt_req  (halt_req)
    );

    a_r5_one_line: assert property (@(posedge clk) disable iff (rst)
        $countones(lines) == 1);

    a_r6_acc_pulse: assert property (@(posedge clk) disable iff (rst)
        acc_we |=> !acc_we);

    a_r7_store_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    a_r7_store_addr: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr == operand);

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    a_r10_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> !(acc_we || mem_we || pc_load));

    a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({acc_we, mem_we, pc_load}) <= 1);

endmodule

// File: tb/sim_fetch_decode_ctrl.sv
module sim_fetch_decode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_N      = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] mem_addr;
    logic [7:0] mem_rdata;
    logic       mem_we;
    logic       zero_flag;
    logic       acc_we;
    logic [1:0] alu_op;
    logic       pc_load;
    logic       halted;

    logic [7:0] mem [MEM_N];
    logic [7:0] acc;

    logic [7:0] ref_mem [MEM_N];
    logic [7:0] ref_acc;
    int         ref_pc;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_decode_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .zero_flag (zero_flag),
        .acc_we    (acc_we),
        .alu_op    (alu_op),
        .pc_load   (pc_load),
        .halted    (halted)
    );

    // Memory with one-cycle synchronous read, and the accumulator datapath.
    always @(posedge clk) begin
        if (mem_we)
            mem[mem_addr] <= acc;
        mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        if (rst)
            acc <= 8'd0;
        else if (acc_we) begin
            case (alu_op)
                2'd1:    acc <= acc + mem_rdata;
                2'd2:    acc <= acc - mem_rdata;
                default: acc <= mem_rdata;
            endcase
        end
    end

    assign zero_flag = (acc == 8'd0);

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_quiet(input string tag);
        chk(tag, "strobes {acc_we,mem_we,pc_load,halted}",
            {4'd0, acc_we, mem_we, pc_load, halted}, 8'd0);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic put(input int a, input logic [7:0] v);
        mem[a]     = v;
        ref_mem[a] = v;
    endtask

    // Enter reset, leaving the bench at a negedge with rst high.
    task automatic reset_enter();
        @(negedge clk);
        rst = 1'b1;
        ref_acc = 8'd0;
        ref_pc  = 0;
    endtask

    // R1: hold reset, check quiet outputs, release at a negedge.
    task automatic reset_release();
        step();
        chk_quiet("R1");
        step();
        chk_quiet("R1");
        rst = 1'b0;
    endtask

    // Run one instruction from its first fetch cycle to the next one.
    task automatic do_instr(output bit stop);
        logic [7:0] w;
        logic [2:0] opc;
        logic [4:0] opnd;
        bit         memop, take;
        logic [1:0] exp_alu;
        logic [4:0] hold_addr;
        w     = ref_mem[ref_pc];
        opc   = w[7:5];
        opnd  = w[4:0];
        memop = (opc == 3'd1) || (opc == 3'd3) || (opc == 3'd4);
        take  = (opc == 3'd5) || ((opc == 3'd6) && (ref_acc != 8'd0));
        stop  = 1'b0;

        chk_quiet("R2");                       // ST_MAR
        step();
        chk_quiet("R2");                       // ST_WAIT
        chk("R2", "fetch addr (wait)", {3'd0, mem_addr}, 8'(ref_pc));
        step();
        chk_quiet("R2");                       // ST_MDR
        chk("R12", "fetch addr (mdr)", {3'd0, mem_addr}, 8'(ref_pc));
        step();
        chk_quiet("R3");                       // ST_IR
        step();
        // ST_EXEC
        chk("R7", "mem_we", {7'd0, mem_we}, {7'd0, opc == 3'd2});
        chk("R8", "pc_load", {7'd0, pc_load}, {7'd0, take});
        chk("R11", "acc_we/halted in exec", {6'd0, acc_we, halted}, 8'd0);
        if (opc == 3'd2 || memop)
            chk("R6", "operand addr", {3'd0, mem_addr}, {3'd0, opnd});
        if (opc == 3'd2)
            ref_mem[opnd] = ref_acc;
        ref_pc = take ? int'(opnd) : ((ref_pc + 1) % MEM_N);
        step();
        if (memop) begin
            exp_alu = (opc == 3'd4) ? 2'd2 : ((opc == 3'd3) ? 2'd1 : 2'd0);
            chk("R6", "acc_we", {7'd0, acc_we}, 8'd1);
            chk("R6", "alu_op", {6'd0, alu_op}, {6'd0, exp_alu});
            chk("R6", "no other strobe", {6'd0, mem_we, pc_load}, 8'd0);
            case (opc)
                3'd3:    ref_acc = ref_acc + ref_mem[opnd];
                3'd4:    ref_acc = ref_acc - ref_mem[opnd];
                default: ref_acc = ref_mem[opnd];
            endcase
            step();
        end
        if (opc == 3'd7) begin
            hold_addr = mem_addr;
            for (int i = 0; i < 8; i++) begin
                chk("R10", "halted", {7'd0, halted}, 8'd1);
                chk("R10", "halt strobes", {5'd0, acc_we, mem_we, pc_load}, 8'd0);
                chk("R10", "addr frozen", {3'd0, mem_addr}, {3'd0, hold_addr});
                step();
            end
            stop = 1'b1;
        end
    endtask

    task automatic run_prog(input int max_n, output bit did_halt);
        bit s;
        did_halt = 1'b0;
        for (int i = 0; i < max_n; i++) begin
            do_instr(s);
            if (s) begin
                did_halt = 1'b1;
                break;
            end
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog R2: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        bit h;
        for (int a = 0; a < MEM_N; a++) put(a, 8'd0);

        // Directed program: countdown loop with BNZ taken and not taken (R9),
        // LDA/ADD/SUB/STA/JMP/NOP/HLT (R4, R6, R7, R8, R10, R11).
        reset_enter();
        put(0, {3'd1, 5'd30});   // LDA 30
        put(1, {3'd4, 5'd31});   // SUB 31
        put(2, {3'd2, 5'd29});   // STA 29
        put(3, {3'd6, 5'd1});    // BNZ 1
        put(4, {3'd3, 5'd30});   // ADD 30
        put(5, {3'd5, 5'd7});    // JMP 7
        put(6, {3'd7, 5'd0});    // HLT (skipped)
        put(7, {3'd0, 5'd0});    // NOP
        put(8, {3'd2, 5'd28});   // STA 28
        put(9, {3'd7, 5'd0});    // HLT
        put(28, 8'hEE);
        put(29, 8'hEE);
        put(30, 8'd3);
        put(31, 8'd1);
        reset_release();
        run_prog(40, h);
        chk("R10", "program halted", {7'd0, h}, 8'd1);
        chk("R7", "stored count", mem[29], 8'd0);
        chk("R9", "stored sum", mem[28], 8'd3);

        // R1: reset from halt restarts at address 0 with halted cleared.
        reset_enter();
        for (int a = 0; a < MEM_N; a++) put(a, 8'd0);
        put(0, {3'd5, 5'd29});   // JMP 29; 29..31 NOP, then wrap (R12)
        reset_release();
        chk("R1", "halted cleared", {7'd0, halted}, 8'd0);
        run_prog(9, h);
        chk("R12", "wrap run not halted", {7'd0, h}, 8'd0);

        // Exhaustive sweep over every instruction encoding, with zero and
        // non-zero accumulator before it (R4, R5, R9).
        for (int b = 0; b < 256; b++) begin
            reset_enter();
            for (int a = 0; a < MEM_N; a++) put(a, 8'((a * 37 + b) & 255));
            put(0, {3'd1, 5'd31});
            put(31, (b % 2 == 1) ? 8'd0 : 8'd9);
            put(1, 8'(b));
            reset_release();
            run_prog(4, h);
        end

        summary();
        $finish;
    end

endmodule